// File: doc/BRIEF.md
# Serial Command-Word Front End

This block is the serial slave port of a multi-channel measurement device. A host frames each transaction by pulling an active-low enable low for exactly sixteen serial clocks. The block collects one 16-bit command word, most significant bit first, and acts on it once the enable returns high. Every signal on the serial side is sampled in the core clock domain through a synchronizer. The serial clock must therefore stay high for at least two core clock periods and low for at least two.

A command word carries a 3-bit operation code, an active-low broadcast flag, a 4-bit channel number and an 8-bit argument. The operation code is made of bit 15 followed by bits 13:12. Write operations do one of three things: set an internal register pointer, write a data byte to the register file at that pointer, or strobe a command code into the core. A low-half read first sets the pointer to the argument. It then captures the 32-bit word the register file returns into a hold register. The low half of that word leaves on the data-out pin during the next frame, and a high-half read sends the upper half the same way. Because the output shifter moves one bit on every serial rising edge, the reply to one command leaves while the next command comes in.

Broadcast (flag 0) is meant for the three write operations. A read with flag 0 is only sound when a single channel sits on the bus; the block accepts it without comparing addresses. A ready output goes low while an accepted frame is processed.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A frame is executed only when enable rises after exactly 16 serial rising edges were counted while enable was low. A frame with 15 or 17 edges changes no pointer, writes nothing, strobes nothing and keeps ready high.
- R2: Operation code 001 ({bit15,bit13,bit12}) loads the argument (bits 7:0) into the register pointer, which drives `rf_addr`.
- R3: Operation code 010 issues one single-cycle `rf_we` pulse, with `rf_addr` equal to the pointer and `rf_wdata` equal to the argument.
- R4: Operation code 011 issues one single-cycle `cmd_strobe` pulse with `cmd_code` equal to the argument; `rf_we` and `cmd_strobe` are never high together.
- R5: With bit 14 = 0 a command is accepted whatever bits 11:8 hold. With bit 14 = 1 it is accepted only if bits 11:8 equal `chan_id`, and otherwise it has no effect.
- R6: Operation code 000 is ignored: the pointer stays, nothing is written or strobed, and the output shifter is not reloaded.
- R7: Operation code 100 loads the pointer with the argument, captures `rf_rdata` into the 32-bit hold register, and sends hold bits 15:0 MSB first during the next frame.
- R8: Operation code 101 sends hold bits 31:16 MSB first during the next frame.
- R9: Operation codes 110 and 111 change nothing but reload the output shifter with the half most recently sent, so it is repeated in the next frame.
- R10: `spi_sdo` presents one shifter bit per serial rising edge, MSB first, and is 0 whenever the synchronized enable is high. After a frame that did not reload the shifter, the next frame sends all zeros.
- R11: `spi_rdy` is high when idle and goes low after each accepted frame: for 1 core cycle, or for 3 cycles on operation code 100 with address accepted.
- R12: An enable rising edge that reaches the core in the same cycle as the sixteenth serial rising edge still counts that bit, and the frame is executed.
- R13: After reset `rf_addr` is 0, `spi_rdy` is 1, and `rf_we`, `cmd_strobe` and `spi_sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_id | input | 4 | Hardware channel number of this device (strap, normally 0) |
| spi_sclk | input | 1 | Serial clock from host |
| spi_sen_n | input | 1 | Active-low frame enable |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out, 0 while enable is high |
| spi_rdy | output | 1 | High when no command is being processed |
| rf_addr | output | 8 | Register pointer toward the register file |
| rf_wdata | output | 8 | Write data byte |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_rdata | input | 32 | Read word from the register file at `rf_addr` |
| cmd_strobe | output | 1 | Single-cycle command strobe |
| cmd_code | output | 8 | Command code valid with `cmd_strobe` |

## Verification
Two events can reach the core in the same cycle: the rising edge of the enable that closes a frame and the sixteenth serial rising edge that supplies its last bit. The bench provokes this by driving both pins high at the same instant, so both pass through identical synchronizers and appear together. It judges the result at the ports: the address write carried by that frame must show up on `rf_addr`, and ready must pulse exactly once. The same bench also runs ordinary frames in which the enable rises well after the last clock, which serve as the reference.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int WORD_W = 16;
  localparam int ARG_W  = 8;
  localparam int CHAN_W = 4;

  typedef enum logic [2:0] {
    OP_RSV  = 3'b000,
    OP_SETP = 3'b001,
    OP_WDAT = 3'b010,
    OP_WCMD = 3'b011,
    OP_RLO  = 3'b100,
    OP_RHI  = 3'b101,
    OP_REP0 = 3'b110,
    OP_REP1 = 3'b111
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              bcast_n;
    logic [CHAN_W-1:0] chan;
    logic [ARG_W-1:0]  arg;
  } cmd_t;

  // Split a raw word: operation code = {bit15, bit13, bit12}.
  function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.op      = op_e'({w[15], w[13], w[12]});
    c.bcast_n = w[14];
    c.chan    = w[11:8];
    c.arg     = w[7:0];
    return c;
  endfunction

  function automatic logic addressed(input cmd_t c, input logic [CHAN_W-1:0] id);
    return (!c.bcast_n) || (c.chan == id);
  endfunction

  function automatic logic is_repeat(input op_e op);
    return op[2] & op[1];
  endfunction

endpackage

// File: rtl/spi_sync_bits.sv
module spi_sync_bits #(
  parameter int              N       = 3,
  parameter int              STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
#(
  parameter int BITS  = WORD_W,
  localparam int CNT_W = $clog2(BITS) + 1,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_take,
  input  logic            sdi_bit,
  input  logic            sen_fall,
  input  logic            sen_rise,
  output logic            frame_ok,
  output logic [BITS-1:0] frame_word
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [BITS-1:0]  word_q, word_nxt;

  always_comb begin
    cnt_nxt  = cnt_q;
    word_nxt = word_q;
    if (sen_fall) begin
      cnt_nxt = '0;
    end else if (bit_take) begin
      word_nxt = {word_q[BITS-2:0], sdi_bit};
      if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    end
  end

  // Count includes a bit taken in the same cycle the enable rises.
  assign frame_ok   = sen_rise && (cnt_nxt == CNT_W'(BITS));
  assign frame_word = word_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      word_q <= word_nxt;
    end
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         msb
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= load_val;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];

endmodule

// File: rtl/spi_cmd_exec.sv
module spi_cmd_exec
  import spi_cmd_pkg::*;
#(
  parameter int  HOLD_W = 32,
  localparam int HALF_W = HOLD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [WORD_W-1:0] frame_word,
  input  logic [CHAN_W-1:0] chan_id,
  input  logic [HOLD_W-1:0] rf_rdata,
  output logic [ARG_W-1:0]  rf_addr,
  output logic [ARG_W-1:0]  rf_wdata,
  output logic              rf_we,
  output logic              cmd_strobe,
  output logic [ARG_W-1:0]  cmd_code,
  output logic              rdy,
  output logic              tx_load,
  output logic [HALF_W-1:0] tx_val
);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_CAPT, ST_PUB} st_e;

  st_e               st_q;
  cmd_t              cmd_q;
  logic [ARG_W-1:0]  ptr_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HALF_W-1:0] last_q;
  logic              hit, run;

  function automatic logic [HALF_W-1:0] pick_half(input logic [HOLD_W-1:0] w, input logic upper);
    return upper ? w[HOLD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  assign hit = addressed(cmd_q, chan_id);
  assign run = (st_q == ST_EXEC) && hit;

  assign rf_we      = run && (cmd_q.op == OP_WDAT);
  assign cmd_strobe = run && (cmd_q.op == OP_WCMD);
  assign rf_wdata   = cmd_q.arg;
  assign cmd_code   = cmd_q.arg;
  assign rf_addr    = ptr_q;
  assign rdy        = (st_q == ST_IDLE);

  assign tx_load = (st_q == ST_PUB) ||
                   (run && ((cmd_q.op == OP_RHI) || is_repeat(cmd_q.op)));

  always_comb begin
    if (st_q == ST_PUB)            tx_val = pick_half(hold_q, 1'b0);
    else if (cmd_q.op == OP_RHI)   tx_val = pick_half(hold_q, 1'b1);
    else                           tx_val = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= '0;
      ptr_q  <= '0;
      hold_q <= '0;
      last_q <= '0;
    end else begin
      if (tx_load) last_q <= tx_val;
      unique case (st_q)
        ST_IDLE: if (frame_ok) begin
          cmd_q <= decode_word(frame_word);
          st_q  <= ST_EXEC;
        end
        ST_EXEC: begin
          if (run && ((cmd_q.op == OP_SETP) || (cmd_q.op == OP_RLO)))
            ptr_q <= cmd_q.arg;
          st_q <= (run && (cmd_q.op == OP_RLO)) ? ST_CAPT : ST_IDLE;
        end
        ST_CAPT: begin
          hold_q <= rf_rdata;
          st_q   <= ST_PUB;
        end
        ST_PUB:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int HOLD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] chan_id,
  input  logic              spi_sclk,
  input  logic              spi_sen_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_rdy,
  output logic [ARG_W-1:0]  rf_addr,
  output logic [ARG_W-1:0]  rf_wdata,
  output logic              rf_we,
  input  logic [HOLD_W-1:0] rf_rdata,
  output logic              cmd_strobe,
  output logic [ARG_W-1:0]  cmd_code
);

  localparam int HALF_W = HOLD_W / 2;

  logic [2:0]        lvl;
  logic [1:0]        edge_prev;
  logic              sclk_rise, sen_fall, sen_rise, sen_active, bit_take;
  logic              frame_ok, exec_start, tx_load, tx_msb;
  logic [WORD_W-1:0] frame_word;
  logic [HALF_W-1:0] tx_val;

  // lvl[0] = clock, lvl[1] = enable (active low), lvl[2] = data in
  spi_sync_bits #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sdi, spi_sen_n, spi_sclk}),
    .dout (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev <= 2'b10;
    else        edge_prev <= lvl[1:0];
  end

  assign sclk_rise  = lvl[0] & ~edge_prev[0];
  assign sen_fall   = ~lvl[1] & edge_prev[1];
  assign sen_rise   = lvl[1] & ~edge_prev[1];
  assign sen_active = ~lvl[1];
  assign bit_take   = sclk_rise & ~edge_prev[1];

  spi_frame_rx #(.BITS(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_take  (bit_take),
    .sdi_bit   (lvl[2]),
    .sen_fall  (sen_fall),
    .sen_rise  (sen_rise),
    .frame_ok  (frame_ok),
    .frame_word(frame_word)
  );

  spi_cmd_exec #(.HOLD_W(HOLD_W)) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_ok  (frame_ok),
    .frame_word(frame_word),
    .chan_id   (chan_id),
    .rf_rdata  (rf_rdata),
    .rf_addr   (rf_addr),
    .rf_wdata  (rf_wdata),
    .rf_we     (rf_we),
    .cmd_strobe(cmd_strobe),
    .cmd_code  (cmd_code),
    .rdy       (spi_rdy),
    .tx_load   (tx_load),
    .tx_val    (tx_val)
  );

  spi_tx_shift #(.W(HALF_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (bit_take),
    .load    (tx_load),
    .load_val(tx_val),
    .msb     (tx_msb)
  );

  assign exec_start = frame_ok & spi_rdy;
  assign spi_sdo    = sen_active & tx_msb;

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic       rf_we,
  input logic       cmd_strobe,
  input logic       sdo,
  input logic       sen_active,
  input logic       exec_start,
  input logic [7:0] rf_addr
);

  assert_we_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !rdy);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, cmd_strobe}));

  assert_exec_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !rdy);

  assert_busy_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && $past(!rdy) && $past(!rdy, 2)) |=> rdy);

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_active |-> !sdo);

  assert_ptr_moves_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rf_addr) |-> $past(!rdy));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy       (spi_rdy),
  .rf_we     (rf_we),
  .cmd_strobe(cmd_strobe),
  .sdo       (spi_sdo),
  .sen_active(sen_active),
  .exec_start(exec_start),
  .rf_addr   (rf_addr)
);

// File: tb/spi_cmd_frontend_test.sv
module spi_cmd_frontend_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  chan_id = 4'h0;
  logic        sclk = 0, sen_n = 1, sdi = 0;
  logic        sdo, rdy, rf_we, cmd_strobe;
  logic [7:0]  rf_addr, rf_wdata, cmd_code;
  logic [31:0] rf_rdata;

  int n_chk = 0, n_bad = 0;
  int rdy_low = 0, we_cnt = 0, stb_cnt = 0;
  logic [7:0] we_addr = 0, we_data = 0, stb_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Register-file stub owned by the bench: byte3 = a^5A, byte2 = C3, byte1 = ~a, byte0 = a
  function automatic logic [31:0] stub_word(input logic [7:0] a);
    logic [31:0] w;
    w[7:0]   = a;
    w[15:8]  = ~a;
    w[23:16] = 8'hC3;
    w[31:24] = a ^ 8'h5A;
    return w;
  endfunction

  assign rf_rdata = stub_word(rf_addr);

  spi_cmd_frontend uut (
    .clk(clk), .rst_n(rst_n), .chan_id(chan_id),
    .spi_sclk(sclk), .spi_sen_n(sen_n), .spi_sdi(sdi), .spi_sdo(sdo), .spi_rdy(rdy),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rdy) rdy_low++;
      if (rf_we) begin we_cnt++; we_addr = rf_addr; we_data = rf_wdata; end
      if (cmd_strobe) begin stb_cnt++; stb_code = cmd_code; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input bit coinc,
                            output logic [15:0] got);
    got = '0;
    rdy_low = 0;
    sen_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      repeat (3) @(negedge clk);
      if (i < 16) got[15-i] = sdo;
      sclk = 1;
      if (coinc && i == nbits - 1) sen_n = 1;
      repeat (3) @(negedge clk);
      sclk = 0;
    end
    if (!coinc) begin
      repeat (3) @(negedge clk);
      sen_n = 1;
    end
    sdi = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R13 rdy", rdy, 1);
    check("R13 rf_addr", rf_addr, 0);
    check("R13 rf_we", rf_we, 0);
    check("R13 cmd_strobe", cmd_strobe, 0);
    check("R13 sdo", sdo, 0);
  endtask

  task automatic t_set_pointer;
    logic [15:0] g;
    send_frame(16'h1001, 16, 0, g);
    check("R2 pointer after 0x1001", rf_addr, 8'h01);
    check("R11 rdy low cycles on write", rdy_low, 1);
  endtask

  task automatic t_data_write;
    logic [15:0] g;
    chan_id = 4'h4;
    send_frame(16'h6448, 16, 0, g);
    check("R3 write count", we_cnt, 1);
    check("R3 write addr", we_addr, 8'h01);
    check("R3 write data", we_data, 8'h48);
    send_frame(16'h6348, 16, 0, g);
    check("R5 mismatched channel ignored", we_cnt, 1);
    send_frame(16'h2799, 16, 0, g);
    check("R5 broadcast write count", we_cnt, 2);
    check("R5 broadcast write data", we_data, 8'h99);
  endtask

  task automatic t_command;
    logic [15:0] g;
    send_frame(16'h3000, 16, 0, g);
    check("R4 strobe count", stb_cnt, 1);
    check("R4 strobe code", stb_code, 8'h00);
    send_frame(16'h7455, 16, 0, g);
    check("R4 unicast strobe count", stb_cnt, 2);
    check("R4 unicast strobe code", stb_code, 8'h55);
    check("R4 no stray write", we_cnt, 2);
  endtask

  task automatic t_reserved;
    logic [15:0] g;
    send_frame(16'h4401, 16, 0, g);
    check("R6 reserved keeps pointer", rf_addr, 8'h01);
    check("R6 reserved no write", we_cnt, 2);
    check("R6 reserved no strobe", stb_cnt, 2);
  endtask

  task automatic t_reads;
    logic [15:0] g;
    logic [31:0] e;
    e = stub_word(8'h07);
    chan_id = 4'h0;
    send_frame(16'h8007, 16, 0, g);
    check("R7 pointer on read-low", rf_addr, 8'h07);
    check("R11 rdy low cycles on read-low", rdy_low, 3);
    check("R10 sdo idle with data held", sdo, 0);
    send_frame(16'h9000, 16, 0, g);
    check("R7 low half shifted out", g, e[15:0]);
    send_frame(16'hA000, 16, 0, g);
    check("R8 high half shifted out", g, e[31:16]);
    send_frame(16'hA000, 16, 0, g);
    check("R9 repeat sends last half", g, e[31:16]);
    send_frame(16'h0000, 16, 0, g);
    check("R9 repeat half again", g, e[31:16]);
    send_frame(16'h0000, 16, 0, g);
    check("R10 zeros after non-loading frame", g, 16'h0000);
    check("R6 pointer after reserved", rf_addr, 8'h07);
  endtask

  task automatic t_unicast_read;
    logic [15:0] g;
    logic [31:0] e;
    e = stub_word(8'h3C);
    chan_id = 4'h4;
    send_frame(16'hC53C, 16, 0, g);
    check("R5 mismatched read ignored", rf_addr, 8'h07);
    send_frame(16'hC43C, 16, 0, g);
    check("R7 unicast read pointer", rf_addr, 8'h3C);
    send_frame(16'hE400, 16, 0, g);
    check("R7 unicast low half", g, e[15:0]);
  endtask

  task automatic t_bad_length;
    logic [15:0] g;
    send_frame(16'h1055, 15, 0, g);
    check("R1 short frame pointer", rf_addr, 8'h3C);
    check("R1 short frame rdy", rdy_low, 0);
    send_frame(16'h1055, 17, 0, g);
    check("R1 long frame pointer", rf_addr, 8'h3C);
    check("R1 long frame rdy", rdy_low, 0);
  endtask

  task automatic t_coincident;
    logic [15:0] g;
    send_frame(16'h1022, 16, 1, g);
    check("R12 coincident frame pointer", rf_addr, 8'h22);
    check("R12 coincident rdy pulse", rdy_low, 1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_set_pointer();
    t_data_write();
    t_command();
    t_reserved();
    t_reads();
    t_unicast_read();
    t_bad_length();
    t_coincident();
    finish_run();
  end

endmodule